// File: doc/BRIEF.md
# Serial Transmitter with Trimmable Final Byte

This block drains a byte-wide transmit FIFO and sends its contents as a serial bit stream. Each byte goes out least significant bit first. The block sends one bit for each pulse of a bit-clock enable. A 3-bit length setting in a small control register sets how many bits of the final byte are sent. This lets a frame end on any bit, not only on a byte boundary. The block does no line coding, modulation, parity or checksum generation. Those belong to the stages around it.

A host loads the FIFO and writes the tail length. It then pulses `start`. The block pops one byte at a time. The byte after which the FIFO reads empty is the final byte of the frame. The tail length is captured when the frame starts. When the frame ends, the block raises a one-cycle `done` pulse and resets the tail length to zero. The exception is a host write made during the frame: that value is kept and is used by the next frame.

Top module: `partial_tail_tx`

## Requirements
- R1: After reset, `bit_valid`, `done` and `fifo_rd` are low, and the control register reads 0x00.
- R2: The control register sits at address `REG_ADDR` (default 0x0F). Bits 2:0 hold the tail length and bits 7:3 always read 0. Writes to any other address leave the register unchanged, and reads at any other address return 0x00.
- R3: Each `bit_clk_en` pulse taken during shifting produces one bit on `ser_bit`, and `bit_valid` is high for exactly that one following cycle. Within a byte, bits go out least significant bit first. An enable that lands in the single load cycle after each pop is not used.
- R4: Every byte of a frame except the final one is sent in full, all 8 bits.
- R5: For the final byte, a tail length n from 1 to 7 sends that byte's n lowest-order bits. A tail length of 0 sends all 8 bits.
- R6: One cycle after each pop, the block samples the FIFO empty flag. If the FIFO is empty then, the popped byte is the final byte. A byte pushed after that point is not part of the frame and stays in the FIFO.
- R7: A `start` pulse while the FIFO is empty does nothing: no pop, no bits, no `done`, and the tail length is unchanged.
- R8: `done` is a one-cycle pulse in the cycle right after the final `bit_valid` cycle. On that same cycle the tail length reads 0, unless the host wrote the register during the frame.
- R9: The tail length is latched when a frame starts. A write during the frame does not change the current frame. The written value survives the end-of-frame clear and applies to the next frame.
- R10: `fifo_rd` is asserted only while the FIFO is non-empty, exactly once per byte sent.
- R11: A `start` pulse while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | FIFO has no byte available |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head byte at this clock edge |
| start | input | 1 | Begin a frame |
| bit_clk_en | input | 1 | Bit-rate enable; one bit per pulse |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | ADDR_W | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data (combinational) |
| ser_bit | output | 1 | Serial output bit |
| bit_valid | output | 1 | `ser_bit` carries a new bit this cycle |
| done | output | 1 | Frame complete pulse |

## Verification
A wrong bit counter or a mis-sampled final-byte flag shows up directly as a wrong number of `bit_valid` pulses before `done`, and this is visible within one byte time of the fault. A shift register fault appears as a wrong `ser_bit` value on the very next valid bit. A broken tail-length register shows up at `cfg_rdata` in the `done` cycle: it either fails to clear, or it clears a value that should have been kept. A stuck or early pop shows up as a FIFO read pointer that differs from the number of bytes the frame should have consumed.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = $clog2(BYTE_W);
    localparam int CNT_W  = LEN_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH
    } tx_state_e;

    // Per-frame context: captured tail length and whether the byte now
    // in the shifter is the final one of the frame.
    typedef struct packed {
        logic [LEN_W-1:0] tail_len;
        logic             tail_now;
    } frame_ctx_t;

    // Number of bits to send from the byte in flight.
    function automatic logic [CNT_W-1:0] bits_for_byte(
        input logic [LEN_W-1:0] tl,
        input logic             is_tail
    );
        if (is_tail && tl != '0)
            return {1'b0, tl};
        return CNT_W'(BYTE_W);
    endfunction

endpackage

// File: rtl/ptx_tail_reg.sv
module ptx_tail_reg
    import ptx_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              frame_active,
    input  logic              frame_end,
    output logic [LEN_W-1:0]  tail_len
);

    logic             hit;
    logic             pend_q;
    logic [LEN_W-1:0] len_q;
    logic             unused_wdata_hi;

    assign hit             = (addr == REG_ADDR);
    assign unused_wdata_hi = ^wdata[BYTE_W-1:LEN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en && hit)
                len_q <= wdata[LEN_W-1:0];
            else if (frame_end && !pend_q)
                len_q <= '0;

            if (frame_end)
                pend_q <= 1'b0;
            else if (wr_en && hit && frame_active)
                pend_q <= 1'b1;
        end
    end

    assign rdata    = hit ? {{(BYTE_W-LEN_W){1'b0}}, len_q} : '0;
    assign tail_len = len_q;

endmodule

// File: rtl/ptx_shreg.sv
module ptx_shreg
    import ptx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    input  logic              shift,
    output logic              lsb
);

    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= {1'b0, q[BYTE_W-1:1]};
    end

    assign lsb = q[0];

endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
    import ptx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             fifo_empty,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] tail_len_cfg,
    output logic             fifo_pop,
    output logic             shift_adv,
    output logic             frame_end,
    output logic             busy
);

    tx_state_e        state_q, state_d;
    frame_ctx_t       ctx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             byte_done;

    assign byte_done = (cnt_q == (bits_for_byte(ctx_q.tail_len, ctx_q.tail_now) - CNT_W'(1)));

    always_comb begin
        state_d   = state_q;
        fifo_pop  = 1'b0;
        shift_adv = 1'b0;
        frame_end = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    state_d  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (bit_tick) begin
                    shift_adv = 1'b1;
                    if (byte_done) begin
                        if (!ctx_q.tail_now && !fifo_empty) begin
                            fifo_pop = 1'b1;
                            state_d  = ST_LOAD;
                        end else begin
                            state_d = ST_FINISH;
                        end
                    end
                end
            end
            ST_FINISH: begin
                frame_end = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && fifo_pop)
                ctx_q.tail_len <= tail_len_cfg;
            if (state_q == ST_LOAD) begin
                ctx_q.tail_now <= fifo_empty;
                cnt_q          <= '0;
            end else if (shift_adv) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/partial_tail_tx.sv
module partial_tail_tx
    import ptx_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [7:0]        fifo_data,
    output logic              fifo_rd,
    input  logic              start,
    input  logic              bit_clk_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              ser_bit,
    output logic              bit_valid,
    output logic              done
);

    logic             pop_w;
    logic             adv_w;
    logic             end_w;
    logic             busy_w;
    logic             lsb_w;
    logic [LEN_W-1:0] tail_len_w;
    logic             ser_q;
    logic             valid_q;
    logic             done_q;

    ptx_tail_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (cfg_we),
        .addr         (cfg_addr),
        .wdata        (cfg_wdata),
        .rdata        (cfg_rdata),
        .frame_active (busy_w),
        .frame_end    (end_w),
        .tail_len     (tail_len_w)
    );

    ptx_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .fifo_empty   (fifo_empty),
        .bit_tick     (bit_clk_en),
        .tail_len_cfg (tail_len_w),
        .fifo_pop     (pop_w),
        .shift_adv    (adv_w),
        .frame_end    (end_w),
        .busy         (busy_w)
    );

    ptx_shreg u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (pop_w),
        .din   (fifo_data),
        .shift (adv_w),
        .lsb   (lsb_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q   <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (adv_w)
                ser_q <= lsb_w;
            valid_q <= adv_w;
            done_q  <= end_w;
        end
    end

    assign fifo_rd   = pop_w;
    assign ser_bit   = ser_q;
    assign bit_valid = valid_q;
    assign done      = done_q;

endmodule

// File: rtl/ptx_checks.sv
module ptx_checks (
    input logic clk,
    input logic rst,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic bit_clk_en,
    input logic bit_valid,
    input logic done,
    input logic busy
);

    // R10: pops only from a non-empty FIFO
    p_pop_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    // R3: each valid bit is caused by an enable one cycle earlier
    p_valid_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(bit_clk_en));

    // R3: no bits while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bit_valid);

    // R8: done lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done directly follows the final valid bit
    p_done_after_bit_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bit_valid));

endmodule

bind partial_tail_tx ptx_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .bit_clk_en (bit_clk_en),
    .bit_valid  (bit_valid),
    .done       (done),
    .busy       (busy_w)
);

// File: tb/tb_partial_tail_tx.sv
`timescale 1ns/1ps
module tb_partial_tail_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    logic       fifo_rd;
    logic       start = 1'b0;
    logic       bit_clk_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h0F;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       ser_bit;
    logic       bit_valid;
    logic       done;

    always #4 clk = ~clk;

    partial_tail_tx dut (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .start      (start),
        .bit_clk_en (bit_clk_en),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .ser_bit    (ser_bit),
        .bit_valid  (bit_valid),
        .done       (done)
    );

    // show-ahead FIFO model
    logic [7:0] mem [0:15];
    int head = 0;
    int tail = 0;
    assign fifo_empty = (head == tail);
    assign fifo_data  = mem[head % 16];
    always @(posedge clk) if (fifo_rd) head <= head + 1;

    // bit-rate enable: one pulse every third cycle
    int div = 0;
    always @(negedge clk) begin
        if (rst) begin
            div = 0;
            bit_clk_en = 1'b0;
        end else begin
            bit_clk_en = (div == 2);
            div = (div == 2) ? 0 : div + 1;
        end
    end

    // output monitor
    logic       rx_bits [0:63];
    int         rx_n = 0;
    int         done_cnt = 0;
    logic       prev_valid = 1'b0;
    logic       done_follow = 1'b0;
    logic [7:0] rdata_at_done = 8'h00;
    always @(negedge clk) begin
        if (rst) begin
            prev_valid = 1'b0;
        end else begin
            if (bit_valid) begin
                if (rx_n < 64) rx_bits[rx_n] = ser_bit;
                rx_n++;
            end
            if (done) begin
                done_cnt++;
                done_follow   = prev_valid;
                rdata_at_done = cfg_rdata;
            end
            prev_valid = bit_valid;
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int k);
        return 8'((f * 37 + k * 91 + 5) & 255);
    endfunction

    task automatic wr_cfg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_addr = 8'h0F;
    endtask

    task automatic push(input logic [7:0] b);
        mem[tail % 16] = b;
        tail++;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clr_mon();
        rx_n = 0; done_cnt = 0; done_follow = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 3000) begin
            @(negedge clk); n++;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_bits(input int k);
        while (rx_n < k) @(negedge clk);
    endtask

    // compare received stream against expected bytes, LSB first
    function automatic int stream_err(input int f, input int nbits);
        int e = 0;
        for (int i = 0; i < nbits && i < 64; i++) begin
            logic [7:0] b = pat(f, i / 8);
            if (rx_bits[i] !== b[i % 8]) e++;
        end
        return e;
    endfunction

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int h0;
        int expn;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(bit_valid == 0 && done == 0, "R1 bit_valid/done after reset", {bit_valid, done}, 0);
        chk(fifo_rd == 0, "R1 fifo_rd after reset", fifo_rd, 0);
        chk(cfg_rdata == 8'h00, "R1 register after reset", cfg_rdata, 0);

        // R2 register decode and reserved bits
        wr_cfg(8'h0E, 8'h07);
        chk(cfg_rdata == 8'h00, "R2 write to other address ignored", cfg_rdata, 0);
        wr_cfg(8'h0F, 8'hFD);
        chk(cfg_rdata == 8'h05, "R2 only bits 2:0 stored", cfg_rdata, 5);
        @(negedge clk); cfg_addr = 8'h0E;
        @(negedge clk);
        chk(cfg_rdata == 8'h00, "R2 read of other address", cfg_rdata, 0);
        cfg_addr = 8'h0F;

        // R7 start with empty FIFO
        wr_cfg(8'h0F, 8'h03);
        clr_mon(); h0 = head;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(done_cnt == 0, "R7 no done on empty start", done_cnt, 0);
        chk(rx_n == 0, "R7 no bits on empty start", rx_n, 0);
        chk(head == h0, "R7 no pop on empty start", head - h0, 0);
        chk(cfg_rdata == 8'h03, "R7 tail length kept", cfg_rdata, 3);

        // sweep: frame length 1..3 bytes, every tail length
        for (int nb = 1; nb <= 3; nb++) begin
            for (int lb = 0; lb < 8; lb++) begin
                int f = nb * 8 + lb;
                clr_mon(); h0 = head;
                for (int k = 0; k < nb; k++) push(pat(f, k));
                wr_cfg(8'h0F, 8'(lb));
                pulse_start();
                wait_done();
                expn = (nb - 1) * 8 + ((lb == 0) ? 8 : lb);
                chk(rx_n == expn, $sformatf("R4/R5 bit count nb=%0d lb=%0d", nb, lb), rx_n, expn);
                chk(stream_err(f, expn) == 0, $sformatf("R3 LSB-first data nb=%0d lb=%0d", nb, lb),
                    stream_err(f, expn), 0);
                chk(done_cnt == 1 && done_follow, $sformatf("R8 single done after last bit nb=%0d lb=%0d", nb, lb),
                    done_cnt, 1);
                chk(rdata_at_done == 8'h00, $sformatf("R8 tail cleared at done nb=%0d lb=%0d", nb, lb),
                    rdata_at_done, 0);
                chk(head - h0 == nb, $sformatf("R10 pops per frame nb=%0d lb=%0d", nb, lb), head - h0, nb);
            end
        end

        // R9 write during frame: current frame unchanged, value kept for next
        clr_mon(); h0 = head;
        push(pat(40, 0)); push(pat(40, 1));
        wr_cfg(8'h0F, 8'h03);
        pulse_start();
        wait_bits(4);
        wr_cfg(8'h0F, 8'h05);
        wait_done();
        chk(rx_n == 11, "R9 current frame uses latched length", rx_n, 11);
        chk(stream_err(40, 11) == 0, "R9 data of current frame", stream_err(40, 11), 0);
        chk(rdata_at_done == 8'h05, "R9 mid-frame write survives clear", rdata_at_done, 5);
        clr_mon();
        push(pat(41, 0));
        pulse_start();
        wait_done();
        chk(rx_n == 5, "R9 next frame uses written length", rx_n, 5);
        chk(stream_err(41, 5) == 0, "R9 data of next frame", stream_err(41, 5), 0);
        chk(rdata_at_done == 8'h00, "R8 clear after ordinary frame", rdata_at_done, 0);

        // R11 start during frame ignored
        clr_mon(); h0 = head;
        push(pat(42, 0)); push(pat(42, 1));
        wr_cfg(8'h0F, 8'h00);
        pulse_start();
        wait_bits(2);
        pulse_start();
        wait_done();
        chk(rx_n == 16, "R11 restart ignored, bit count", rx_n, 16);
        chk(done_cnt == 1, "R11 restart ignored, done count", done_cnt, 1);
        chk(head - h0 == 2, "R11 restart ignored, pops", head - h0, 2);

        // R6 byte pushed after the final byte is decided stays queued
        clr_mon(); h0 = head;
        push(pat(43, 0));
        wr_cfg(8'h0F, 8'h04);
        pulse_start();
        wait_bits(2);
        push(pat(43, 1));
        wait_done();
        chk(rx_n == 4, "R6 late push not in frame, bit count", rx_n, 4);
        chk(stream_err(43, 4) == 0, "R6 data of trimmed byte", stream_err(43, 4), 0);
        chk(head - h0 == 1 && !fifo_empty, "R6 late byte left in FIFO", head - h0, 1);
        clr_mon();
        pulse_start();
        wait_done();
        chk(rx_n == 8, "R6 queued byte sent next frame", rx_n, 8);
        begin
            int e = 0;
            logic [7:0] b = pat(43, 1);
            for (int i = 0; i < 8; i++) if (rx_bits[i] !== b[i]) e++;
            chk(e == 0, "R6 queued byte data", e, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule